// File: doc/BRIEF.md
# Fractionally Adjustable Nanosecond Timer

A free-running time counter for precision time protocol hardware. On every 8 ns clock cycle it advances a 40-bit nanosecond count by a fixed step of 8. A 32-bit sub-nanosecond accumulator sits beside the count. A programmable signed trim is added to it, or taken from it, on every running cycle. A carry out of the accumulator makes that cycle's step 9 ns, and a borrow makes it 7 ns. The average rate can therefore be pulled by up to roughly ±62.5 million parts per billion.

Software reaches the timer through a small word-wide register port. Reading the fraction word captures the whole nanosecond count in a snapshot, so the following reads of the low and high words return one consistent time. Writing the low word only stages it. The count is loaded atomically when the high word is written. A stop bit in the control register freezes the timer.

Top module: `frac_ns_timer`

## Requirements
- R1: After reset the nanosecond count, the fraction, the trim register (address 3) and the control register (address 4) are all zero, and the timer runs.
- R2: While running with a trim magnitude of zero, the count advances by exactly 8 on every clock edge.
- R3: A trim word with bit 31 clear adds its bits 30:0 to the fraction each running cycle. From a fraction of zero, after K cycles the count has grown by 8K + floor(K·m/2^32), and the fraction reads (K·m) mod 2^32. This holds up to the magnitude for 62,499,999 ppb, which is 62499999·2^26/1953125.
- R4: A trim word with bit 31 set subtracts bits 30:0 from the fraction each running cycle. From zero, after K cycles the count has grown by 8K − ceil(K·m/2^32), and the fraction reads (−K·m) mod 2^32.
- R5: The 40-bit count wraps modulo 2^40.
- R6: While bit 31 of the control register is 1, the count and the fraction hold their values. Writing 0 to it resumes counting on the following edge.
- R7: A read of address 0 returns the live fraction and captures the count. Later reads of address 1 (bits 31:0) and address 2 (bits 39:32 in bits 7:0, with bits 31:8 zero) return the captured value, however long the timer has run since.
- R8: A write to address 1 is held and has no effect on the count. A write to address 2 loads the count with {data[7:0], held low word} on that edge and clears the fraction, and counting continues from the loaded value.
- R9: The trim register reads back exactly as written. The control register reads back bit 31 as written, with all other bits zero. Addresses 5 to 7 read zero, and read data is zero when no read is strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 125 MHz timer clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, valid in the strobe cycle |
| time_ns_o | output | 40 | Live nanosecond count |

## Verification
A wrong fraction or a wrong carry or borrow shows at time_ns_o as a step other than 8 on the very edge where it happens. A closed-form count and a fraction read after a stop expose any drift that builds up over a run. A bad snapshot or staging register shows only when the low and high words are read back after capture or load. The bench therefore reads them many cycles later, when the live count has moved well away from the held value. The trim sweep covers zero, positive and negative magnitudes, the largest magnitude, negative zero and the maximum rate, and checks every result against arithmetic.

// File: rtl/ts_pkg.sv
package ts_pkg;
  localparam int unsigned TS_NS_W   = 40;
  localparam int unsigned TS_FRAC_W = 32;
  localparam int unsigned TS_REG_W  = 32;
  localparam int unsigned TS_ADDR_W = 3;
  localparam int unsigned TS_STEP   = 8;

  // word addresses
  localparam int unsigned TS_A_FRAC = 0;
  localparam int unsigned TS_A_LO   = 1;
  localparam int unsigned TS_A_HI   = 2;
  localparam int unsigned TS_A_ADJ  = 3;
  localparam int unsigned TS_A_CTRL = 4;
endpackage

// File: rtl/ts_frac_accum.sv
module ts_frac_accum
  import ts_pkg::*;
#(
  parameter int unsigned FRAC_W = TS_FRAC_W,
  parameter int unsigned REG_W  = TS_REG_W
) (
  input  logic [FRAC_W-1:0] frac_i,
  input  logic [REG_W-1:0]  adj_i,
  output logic [FRAC_W-1:0] frac_nxt_o,
  output logic              carry_o,
  output logic              borrow_o
);
  localparam int unsigned MAG_W = REG_W - 1;

  logic [FRAC_W-1:0] mag;
  logic [FRAC_W:0]   sum, diff;
  logic              neg;

  generate
    if (MAG_W >= FRAC_W) begin : g_trunc
      assign mag = adj_i[FRAC_W-1:0];
    end else begin : g_ext
      assign mag = FRAC_W'(adj_i[MAG_W-1:0]);
    end
  endgenerate

  assign neg  = adj_i[REG_W-1];
  assign sum  = {1'b0, frac_i} + {1'b0, mag};
  assign diff = {1'b0, frac_i} - {1'b0, mag};

  always_comb begin
    if (neg) begin
      frac_nxt_o = diff[FRAC_W-1:0];
      carry_o    = 1'b0;
      borrow_o   = diff[FRAC_W];
    end else begin
      frac_nxt_o = sum[FRAC_W-1:0];
      carry_o    = sum[FRAC_W];
      borrow_o   = 1'b0;
    end
  end
endmodule

// File: rtl/ts_ns_counter.sv
module ts_ns_counter
  import ts_pkg::*;
#(
  parameter int unsigned NS_W   = TS_NS_W,
  parameter int unsigned FRAC_W = TS_FRAC_W,
  parameter int unsigned STEP   = TS_STEP
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              load_i,
  input  logic [NS_W-1:0]   load_ns_i,
  input  logic [FRAC_W-1:0] frac_nxt_i,
  input  logic              carry_i,
  input  logic              borrow_i,
  output logic [NS_W-1:0]   ns_o,
  output logic [FRAC_W-1:0] frac_o
);
  logic [NS_W-1:0] ns_q, ns_step;
  logic [FRAC_W-1:0] frac_q;

  // step of STEP, STEP+1 or STEP-1, wrapping at 2^NS_W
  assign ns_step = ns_q + NS_W'(STEP) + NS_W'(carry_i) - NS_W'(borrow_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ns_q   <= '0;
      frac_q <= '0;
    end else if (load_i) begin
      ns_q   <= load_ns_i;
      frac_q <= '0;
    end else if (run_i) begin
      ns_q   <= ns_step;
      frac_q <= frac_nxt_i;
    end
  end

  assign ns_o   = ns_q;
  assign frac_o = frac_q;
endmodule

// File: rtl/ts_reg_if.sv
module ts_reg_if
  import ts_pkg::*;
#(
  parameter int unsigned NS_W   = TS_NS_W,
  parameter int unsigned FRAC_W = TS_FRAC_W,
  parameter int unsigned REG_W  = TS_REG_W,
  parameter int unsigned ADDR_W = TS_ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [NS_W-1:0]   ns_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic [REG_W-1:0]  adj_o,
  output logic              run_o,
  output logic              load_o,
  output logic [NS_W-1:0]   load_ns_o
);
  localparam int unsigned HI_W = NS_W - REG_W;
  localparam logic [ADDR_W-1:0] A_FRAC = ADDR_W'(TS_A_FRAC);
  localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(TS_A_LO);
  localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(TS_A_HI);
  localparam logic [ADDR_W-1:0] A_ADJ  = ADDR_W'(TS_A_ADJ);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(TS_A_CTRL);

  logic [REG_W-1:0] lo_hold_q, adj_q;
  logic [NS_W-1:0]  snap_q;
  logic             stop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_hold_q <= '0;
      adj_q     <= '0;
      stop_q    <= 1'b0;
    end else if (wr_i) begin
      unique case (addr_i)
        A_LO:    lo_hold_q <= wdata_i;
        A_ADJ:   adj_q     <= wdata_i;
        A_CTRL:  stop_q    <= wdata_i[REG_W-1];
        default: ;
      endcase
    end
  end

  // lowest word read latches the full count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      snap_q <= '0;
    else if (rd_i && addr_i == A_FRAC) snap_q <= ns_i;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (addr_i)
        A_FRAC:  rdata_o = REG_W'(frac_i);
        A_LO:    rdata_o = snap_q[REG_W-1:0];
        A_HI:    rdata_o = REG_W'(snap_q[NS_W-1:REG_W]);
        A_ADJ:   rdata_o = adj_q;
        A_CTRL:  rdata_o = {stop_q, {(REG_W-1){1'b0}}};
        default: rdata_o = '0;
      endcase
    end
  end

  assign adj_o     = adj_q;
  assign run_o     = !stop_q;
  assign load_o    = wr_i && (addr_i == A_HI);
  assign load_ns_o = {wdata_i[HI_W-1:0], lo_hold_q};
endmodule

// File: rtl/frac_ns_timer.sv
module frac_ns_timer
  import ts_pkg::*;
#(
  parameter int unsigned NS_W   = TS_NS_W,
  parameter int unsigned FRAC_W = TS_FRAC_W,
  parameter int unsigned REG_W  = TS_REG_W,
  parameter int unsigned ADDR_W = TS_ADDR_W,
  parameter int unsigned STEP   = TS_STEP
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic [NS_W-1:0]   time_ns_o
);
  logic [REG_W-1:0]  adj_q;
  logic              run, load_en, carry, borrow;
  logic [NS_W-1:0]   load_ns;
  logic [FRAC_W-1:0] frac_q, frac_nxt;

  ts_reg_if #(
    .NS_W(NS_W), .FRAC_W(FRAC_W), .REG_W(REG_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (reg_wr_i),
    .rd_i      (reg_rd_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .ns_i      (time_ns_o),
    .frac_i    (frac_q),
    .rdata_o   (reg_rdata_o),
    .adj_o     (adj_q),
    .run_o     (run),
    .load_o    (load_en),
    .load_ns_o (load_ns)
  );

  ts_frac_accum #(.FRAC_W(FRAC_W), .REG_W(REG_W)) u_accum (
    .frac_i     (frac_q),
    .adj_i      (adj_q),
    .frac_nxt_o (frac_nxt),
    .carry_o    (carry),
    .borrow_o   (borrow)
  );

  ts_ns_counter #(.NS_W(NS_W), .FRAC_W(FRAC_W), .STEP(STEP)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .load_i     (load_en),
    .load_ns_i  (load_ns),
    .frac_nxt_i (frac_nxt),
    .carry_i    (carry),
    .borrow_i   (borrow),
    .ns_o       (time_ns_o),
    .frac_o     (frac_q)
  );
endmodule

// File: rtl/ts_timer_chk.sv
module ts_timer_chk #(
  parameter int unsigned NS_W  = 40,
  parameter int unsigned REG_W = 32,
  parameter int unsigned HI_W  = 8
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  run_i,
  input logic                  load_i,
  input logic                  adj_zero_i,
  input logic [NS_W-1:0]       load_ns_i,
  input logic [NS_W-1:0]       time_ns_i,
  input logic                  hi_rd_i,
  input logic [REG_W-HI_W-1:0] rdata_hi_i
);
  // R2
  nominal_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i && adj_zero_i) |=> time_ns_i == NS_W'($past(time_ns_i) + NS_W'(8)));

  // R3 R4
  step_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i) |=>
      (NS_W'(time_ns_i - $past(time_ns_i)) >= NS_W'(7)) &&
      (NS_W'(time_ns_i - $past(time_ns_i)) <= NS_W'(9)));

  // R6
  stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !load_i) |=> $stable(time_ns_i));

  // R8
  load_apply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> time_ns_i == $past(load_ns_i));

  // R7
  hi_reserved_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_rd_i |-> rdata_hi_i == '0);
endmodule

bind frac_ns_timer ts_timer_chk #(
  .NS_W(NS_W), .REG_W(REG_W), .HI_W(NS_W - REG_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .run_i      (run),
  .load_i     (load_en),
  .adj_zero_i (adj_q[REG_W-2:0] == '0),
  .load_ns_i  (load_ns),
  .time_ns_i  (time_ns_o),
  .hi_rd_i    (reg_rd_i && reg_addr_i == 3'd2),
  .rdata_hi_i (reg_rdata_o[REG_W-1:NS_W-REG_W])
);

// File: tb/frac_ns_timer_tb.sv
module frac_ns_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [39:0] ns;
  int          cyc = 0;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  frac_ns_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .time_ns_o(ns)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d, output int edge_n);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0; edge_n = cyc;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d, output logic [39:0] ns_at);
    @(negedge clk); rd = 1'b1; addr = a;
    #2 d = rdata; ns_at = ns;
    @(negedge clk); rd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2;
    logic [39:0] t, t_cap;
    int e, e_r, e_s;
    logic [31:0] adj_list [8];
    logic [31:0] ppb_mag;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 count after reset", ns, 0);
    rd_reg(3, d, t); chk("R1 trim after reset", d, 0);
    rd_reg(4, d, t); chk("R1 ctrl after reset", d, 0);
    rd_reg(0, d, t); chk("R1 fraction after reset", d, 0);

    // R2 nominal stepping
    @(negedge clk); t = ns;
    for (int j = 1; j <= 6; j++) begin
      @(negedge clk);
      chk("R2 nominal step", ns, 40'(t + 40'(8 * j)));
    end

    // R9 readback
    wr_reg(3, 32'h8123_4567, e); rd_reg(3, d, t); chk("R9 trim readback", d, 32'h8123_4567);
    wr_reg(4, 32'hFFFF_FFFF, e); rd_reg(4, d, t); chk("R9 ctrl readback", d, 32'h8000_0000);
    for (int a = 5; a < 8; a++) begin
      rd_reg(3'(a), d, t); chk("R9 unused address", d, 0);
    end
    @(negedge clk); chk("R9 no strobe reads zero", rdata, 0);

    // R6 stopped
    @(negedge clk); t = ns;
    rd_reg(0, d, t_cap);
    repeat (6) @(negedge clk);
    chk("R6 count holds while stopped", ns, t);
    rd_reg(0, d2, t_cap); chk("R6 fraction holds while stopped", d2, d);

    // R3 R4 R8 trim sweep, timer stopped on entry
    ppb_mag = 32'((64'd62499999 << 26) / 64'd1953125);
    adj_list = '{32'h0000_0000, 32'h4000_0000, ppb_mag, 32'h0000_0001,
                 32'hC000_0000, 32'hFFFF_FFFF, 32'h8000_0001, 32'h8000_0000};
    for (int i = 0; i < 8; i++) begin
      logic [39:0] base, exp_ns;
      logic [63:0] prod;
      logic [31:0] exp_fr;
      int k;
      string tag;
      base = 40'h12_3456_7000 + 40'(i) * 40'h1_0000_0001;
      tag = adj_list[i][31] ? "R4 negative trim" : "R3 positive trim";
      wr_reg(3, adj_list[i], e);
      wr_reg(1, base[31:0], e);
      wr_reg(2, {24'hABCDEF, base[39:32]}, e);
      chk("R8 load while stopped", ns, base);
      rd_reg(0, d, t); chk("R8 fraction cleared by load", d, 0);
      wr_reg(4, 0, e_r);
      repeat (10 + 7 * i) @(negedge clk);
      wr_reg(4, 32'h8000_0000, e_s);
      k = e_s - e_r;
      prod = 64'(k) * 64'(adj_list[i][30:0]);
      if (adj_list[i][31]) begin
        exp_ns = base + 40'(8 * k) - 40'((prod + 64'hFFFF_FFFF) >> 32);
        exp_fr = 32'(64'd0 - prod);
      end else begin
        exp_ns = base + 40'(8 * k) + 40'(prod >> 32);
        exp_fr = prod[31:0];
      end
      rd_reg(0, d, t); chk({tag, " fraction"}, d, exp_fr);
      rd_reg(1, d, t); chk({tag, " count low"}, d, exp_ns[31:0]);
      rd_reg(2, d, t); chk({tag, " count high (R7 reserved zero)"}, d, {24'h0, exp_ns[39:32]});
    end

    // R8 staged low word has no effect, high word applies
    wr_reg(3, 0, e); wr_reg(4, 0, e);
    @(negedge clk); t = ns;
    wr_reg(1, 32'hDEAD_BEEF, e);
    chk("R8 low write ignored by count", ns, 40'(t + 40'd16));
    wr_reg(2, 32'h0000_0055, e);
    chk("R8 high write loads", ns, 40'h55_DEAD_BEEF);
    @(negedge clk);
    chk("R8 counts on from load", ns, 40'h55_DEAD_BEF7);

    // R5 wrap
    wr_reg(1, 32'hFFFF_FFF0, e);
    wr_reg(2, 32'h0000_00FF, e);
    chk("R5 pre-wrap load", ns, 40'hFF_FFFF_FFF0);
    @(negedge clk); chk("R5 before wrap", ns, 40'hFF_FFFF_FFF8);
    @(negedge clk); chk("R5 wrap to zero", ns, 40'h0);
    @(negedge clk); chk("R5 after wrap", ns, 40'h8);

    // R7 snapshot stays fixed while running
    rd_reg(0, d, t_cap);
    repeat (10) @(negedge clk);
    rd_reg(1, d, t); chk("R7 snapshot low", d, t_cap[31:0]);
    rd_reg(2, d, t); chk("R7 snapshot high", d, {24'h0, t_cap[39:32]});
    rd_reg(1, d2, t); chk("R7 low reread unchanged", d2, t_cap[31:0]);
    chk("R7 live count moved on", (ns != t_cap), 1);

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule